// File: doc/BRIEF.md
# Sync Word Channel

This block runs beside the pixel data lanes of an image sensor readout and produces the lane that carries framing information. A sequencer strobes it with frame start, line start and line end events and supplies the current line address. Each event becomes a typed sync word. When no event is due, the block sends filler words that alternate between two idle codes. Every code pattern is a parameter.

Words leave in fixed slots of `SLOT_DIV` master clock cycles each. A load pulse in the first cycle of each slot tells the serializer to take the parallel word. The data lanes have a fixed conversion pipeline, so the word stream passes through a delay line `ALIGN_SLOTS` slots deep before it reaches the outputs. Each output word carries a valid flag and a type field, so the order and alignment of the stream can be checked downstream.

Top module: `sync_word_channel`

## Requirements
- R1: `loadStrobe` is high for exactly one cycle in every `SLOT_DIV` (default 4) cycles. It is first high in the first cycle after reset is released. `syncValid`, `syncType` and `syncWord` change only at the start of a cycle in which `loadStrobe` is high, and hold for the rest of the slot.
- R2: In reset, and for the first `ALIGN_SLOTS` slots after reset, `syncValid` is 0, `syncType` is 0 and `syncWord` is 0.
- R3: A single uncontended event strobed in any cycle of slot n appears on the outputs in slot n+`ALIGN_SLOTS`.
- R4: The type field is encoded as follows: 0 is idle A, 1 is idle B, 2 is frame start, 3 is line start, 4 is line address, 5 is line end. The frame start, line start and line end words carry `SOF_CODE`, `SOL_CODE` and `EOL_CODE`.
- R5: A line start word is always followed in the very next slot by a type 4 word. That word holds the `lineAddr` sampled with the latest line start strobe before the line start word was chosen, zero-extended to `DATA_W`.
- R6: Slots with no pending event carry idle words. The first idle word after reset is idle A (`IDLEA_CODE`). Each later idle word is the other idle code, and non-idle words in between do not reset this alternation.
- R7: When frame start and line start are pending in the same slot, the frame start word is sent first, then the line start word, then the address word.
- R8: Priority per slot, from highest to lowest: a due address word, then line end, then frame start, then line start, then idle. An event that is not chosen stays pending and is not lost.
- R9: An event strobed in any cycle of a slot, including the last, counts for that slot. Repeated strobes of one kind before its word is sent produce a single word.
- R10: Once `syncValid` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sofEvt | input | 1 | Frame start strobe from the sequencer |
| solEvt | input | 1 | Line start strobe from the sequencer |
| eolEvt | input | 1 | Line end strobe from the sequencer |
| lineAddr | input | ADDR_W | Line address, sampled with the line start strobe |
| loadStrobe | output | 1 | Serializer load pulse, first cycle of each slot |
| syncValid | output | 1 | Output word came from a real slot |
| syncType | output | 3 | Type of the output word |
| syncWord | output | DATA_W | Parallel sync word for the serializer |

## Verification
A strobe in slot n is taken at the clock edge that ends slot n. After that edge it is `ALIGN_SLOTS` register stages from the outputs, so its word first shows in the cycle of the load pulse `ALIGN_SLOTS` slots later. The bench keeps a slot counter, checks the load pulse in every cycle, and compares each slot's word in its first cycle, half a clock away from the edge that updated it, against the entry that its own model computed `ALIGN_SLOTS` slots earlier. In the other cycles of the slot it checks that the outputs have not moved.

// File: rtl/syncwd_pkg.sv
package syncwd_pkg;

  typedef enum logic [2:0] {
    TY_IDLE_A = 3'd0,
    TY_IDLE_B = 3'd1,
    TY_SOF    = 3'd2,
    TY_SOL    = 3'd3,
    TY_ADDR   = 3'd4,
    TY_EOL    = 3'd5
  } wordType_e;

  typedef struct packed {
    logic      tick;
    wordType_e selType;
    logic      capAddr;
    logic      moveAddr;
  } syncStrb_t;

endpackage

// File: rtl/syncCtrl.sv
module syncCtrl
  import syncwd_pkg::*;
#(
  parameter int SLOT_DIV = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sofEvt,
  input  logic      solEvt,
  input  logic      eolEvt,
  output logic      loadStrobe,
  output syncStrb_t strb
);

  localparam int PH_W = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOT_DIV - 1);

  logic [PH_W-1:0] phase;
  logic tick;
  logic sofPend, solPend, eolPend, addrDue, idleB;
  logic effSof, effSol, effEol;
  wordType_e sel;

  assign tick       = (phase == LAST_PH);
  assign loadStrobe = (phase == '0);

  // slot phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= tick ? '0 : phase + 1'b1;
  end

  // slot word choice: a due address first, then line end, frame start, line start
  always_comb begin
    effSof = sofPend | sofEvt;
    effSol = solPend | solEvt;
    effEol = eolPend | eolEvt;
    if (addrDue)     sel = TY_ADDR;
    else if (effEol) sel = TY_EOL;
    else if (effSof) sel = TY_SOF;
    else if (effSol) sel = TY_SOL;
    else if (idleB)  sel = TY_IDLE_B;
    else             sel = TY_IDLE_A;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sofPend <= 1'b0;
      solPend <= 1'b0;
      eolPend <= 1'b0;
      addrDue <= 1'b0;
      idleB   <= 1'b0;
    end else if (tick) begin
      sofPend <= effSof && (sel != TY_SOF);
      solPend <= effSol && (sel != TY_SOL);
      eolPend <= effEol && (sel != TY_EOL);
      addrDue <= (sel == TY_SOL);
      if (sel == TY_IDLE_A || sel == TY_IDLE_B) idleB <= !idleB;
    end else begin
      sofPend <= effSof;
      solPend <= effSol;
      eolPend <= effEol;
    end
  end

  always_comb begin
    strb.tick     = tick;
    strb.selType  = sel;
    strb.capAddr  = solEvt;
    strb.moveAddr = tick && (sel == TY_SOL);
  end

  // R1: one load pulse per slot, never two cycles in a row
  a_r1_load_gap: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe);

endmodule

// File: rtl/syncPath.sv
module syncPath
  import syncwd_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int ADDR_W      = 10,
  parameter int ALIGN_SLOTS = 6,
  parameter logic [DATA_W-1:0] SOF_CODE   = 10'h2AA,
  parameter logic [DATA_W-1:0] SOL_CODE   = 10'h22A,
  parameter logic [DATA_W-1:0] EOL_CODE   = 10'h32A,
  parameter logic [DATA_W-1:0] IDLEA_CODE = 10'h0E9,
  parameter logic [DATA_W-1:0] IDLEB_CODE = 10'h116
) (
  input  logic              clk,
  input  logic              rstN,
  input  syncStrb_t         strb,
  input  logic [ADDR_W-1:0] lineAddr,
  output logic              syncValid,
  output logic [2:0]        syncType,
  output logic [DATA_W-1:0] syncWord
);

  localparam int LAST = ALIGN_SLOTS - 1;

  logic [ADDR_W-1:0] solAddr, addrHold;
  logic [DATA_W-1:0] newWord;
  logic [DATA_W-1:0] wordQ  [ALIGN_SLOTS];
  wordType_e         typeQ  [ALIGN_SLOTS];
  logic              validQ [ALIGN_SLOTS];

  // address capture: latest line start strobe, moved when line start is sent
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      solAddr  <= '0;
      addrHold <= '0;
    end else begin
      if (strb.capAddr) solAddr <= lineAddr;
      if (strb.moveAddr) addrHold <= strb.capAddr ? lineAddr : solAddr;
    end
  end

  always_comb begin
    case (strb.selType)
      TY_SOF:    newWord = SOF_CODE;
      TY_SOL:    newWord = SOL_CODE;
      TY_EOL:    newWord = EOL_CODE;
      TY_ADDR:   newWord = DATA_W'(addrHold);
      TY_IDLE_B: newWord = IDLEB_CODE;
      default:   newWord = IDLEA_CODE;
    endcase
  end

  // alignment delay line, one entry per slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ALIGN_SLOTS; i++) begin
        wordQ[i]  <= '0;
        typeQ[i]  <= TY_IDLE_A;
        validQ[i] <= 1'b0;
      end
    end else if (strb.tick) begin
      for (int i = LAST; i > 0; i--) begin
        wordQ[i]  <= wordQ[i-1];
        typeQ[i]  <= typeQ[i-1];
        validQ[i] <= validQ[i-1];
      end
      wordQ[0]  <= newWord;
      typeQ[0]  <= strb.selType;
      validQ[0] <= 1'b1;
    end
  end

  assign syncWord  = wordQ[LAST];
  assign syncType  = typeQ[LAST];
  assign syncValid = validQ[LAST];

  // R1: outputs only move at a slot boundary
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> ($stable(syncWord) && $stable(syncType) && $stable(syncValid)));

  // R10: valid is sticky
  a_r10_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    syncValid |=> syncValid);

  // R5: line start word is followed by the address word
  a_r5_addr_follows: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && syncValid && syncType == 3'(TY_SOL)) |=> (syncType == 3'(TY_ADDR)));

  generate
    if (ALIGN_SLOTS >= 2) begin : g_idleChk
      // R6: idle A followed by an idle slot gives idle B
      a_r6_idle_alt: assert property (@(posedge clk) disable iff (!rstN)
        (strb.tick && syncValid && syncType == 3'(TY_IDLE_A) && validQ[LAST-1] &&
         (typeQ[LAST-1] == TY_IDLE_A || typeQ[LAST-1] == TY_IDLE_B))
        |=> (syncType == 3'(TY_IDLE_B)));
    end
  endgenerate

endmodule

// File: rtl/sync_word_channel.sv
module sync_word_channel
  import syncwd_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int ADDR_W      = 10,
  parameter int ALIGN_SLOTS = 6,
  parameter int SLOT_DIV    = 4,
  parameter logic [DATA_W-1:0] SOF_CODE   = 10'h2AA,
  parameter logic [DATA_W-1:0] SOL_CODE   = 10'h22A,
  parameter logic [DATA_W-1:0] EOL_CODE   = 10'h32A,
  parameter logic [DATA_W-1:0] IDLEA_CODE = 10'h0E9,
  parameter logic [DATA_W-1:0] IDLEB_CODE = 10'h116
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sofEvt,
  input  logic              solEvt,
  input  logic              eolEvt,
  input  logic [ADDR_W-1:0] lineAddr,
  output logic              loadStrobe,
  output logic              syncValid,
  output logic [2:0]        syncType,
  output logic [DATA_W-1:0] syncWord
);

  syncStrb_t strb;

  syncCtrl #(.SLOT_DIV(SLOT_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sofEvt(sofEvt), .solEvt(solEvt), .eolEvt(eolEvt),
    .loadStrobe(loadStrobe), .strb(strb)
  );

  syncPath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ALIGN_SLOTS(ALIGN_SLOTS),
    .SOF_CODE(SOF_CODE), .SOL_CODE(SOL_CODE), .EOL_CODE(EOL_CODE),
    .IDLEA_CODE(IDLEA_CODE), .IDLEB_CODE(IDLEB_CODE)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .lineAddr(lineAddr),
    .syncValid(syncValid), .syncType(syncType), .syncWord(syncWord)
  );

endmodule

// File: tb/sync_word_channel_tb.sv
module sync_word_channel_tb;

  localparam int DW  = 10;
  localparam int AW  = 10;
  localparam int LAT = 6;
  localparam int DIV = 4;
  localparam int C_SOF = 'h2AA;
  localparam int C_SOL = 'h22A;
  localparam int C_EOL = 'h32A;
  localparam int C_IA  = 'h0E9;
  localparam int C_IB  = 'h116;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofEvt = 1'b0, solEvt = 1'b0, eolEvt = 1'b0;
  logic [AW-1:0] lineAddr = '0;
  logic loadStrobe, syncValid;
  logic [2:0] syncType;
  logic [DW-1:0] syncWord;

  always #4 clk = ~clk;

  sync_word_channel #(
    .DATA_W(DW), .ADDR_W(AW), .ALIGN_SLOTS(LAT), .SLOT_DIV(DIV),
    .SOF_CODE(DW'(C_SOF)), .SOL_CODE(DW'(C_SOL)), .EOL_CODE(DW'(C_EOL)),
    .IDLEA_CODE(DW'(C_IA)), .IDLEB_CODE(DW'(C_IB))
  ) u_dut (
    .clk(clk), .rstN(rstN), .sofEvt(sofEvt), .solEvt(solEvt), .eolEvt(eolEvt),
    .lineAddr(lineAddr), .loadStrobe(loadStrobe), .syncValid(syncValid),
    .syncType(syncType), .syncWord(syncWord)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  int slotIdx = 0;
  int expType [0:511];
  int expWord [0:511];
  string expTag [0:511];
  bit mSof = 0, mSol = 0, mEol = 0, mDue = 0, mIdleB = 0;
  int mLatch = 0, mHold = 0;

  task automatic check(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s slot %0d: got %0h expected %0h", tag, what, slotIdx, got, exp);
    end
  endtask

  task automatic runSlot(string tag, bit [3:0] sofPh, bit [3:0] solPh, bit [3:0] eolPh, int addr);
    int eV, eT, eW, t, w;
    string ct;
    logic v0; logic [2:0] t0; logic [DW-1:0] w0;
    for (int c = 0; c < DIV; c++) begin
      check("R1", "load", int'(loadStrobe), (c == 0) ? 1 : 0);
      if (c == 0) begin
        if (slotIdx < LAT) begin
          eV = 0; eT = 0; eW = 0; ct = "R2";
        end else begin
          eV = 1; eT = expType[slotIdx-LAT]; eW = expWord[slotIdx-LAT];
          ct = expTag[slotIdx-LAT];
        end
        check((slotIdx < LAT) ? "R2" : "R10", "valid", int'(syncValid), eV);
        check(ct, "type", int'(syncType), eT);
        check(ct, "word", int'(syncWord), eW);
        v0 = syncValid; t0 = syncType; w0 = syncWord;
      end else begin
        check("R1", "hold", int'({v0 != syncValid, t0 != syncType, w0 != syncWord}), 0);
      end
      sofEvt = sofPh[c]; solEvt = solPh[c]; eolEvt = eolPh[c];
      lineAddr = AW'(addr);
      @(negedge clk);
    end
    // reference model of the slot decision
    if (|solPh) mLatch = addr % (1 << AW);
    mSof = mSof | (|sofPh); mSol = mSol | (|solPh); mEol = mEol | (|eolPh);
    if (mDue) begin t = 4; w = mHold; mDue = 0; end
    else if (mEol) begin t = 5; w = C_EOL; mEol = 0; end
    else if (mSof) begin t = 2; w = C_SOF; mSof = 0; end
    else if (mSol) begin t = 3; w = C_SOL; mHold = mLatch; mDue = 1; mSol = 0; end
    else begin t = mIdleB ? 1 : 0; w = mIdleB ? C_IB : C_IA; mIdleB = !mIdleB; end
    expType[slotIdx] = t;
    expWord[slotIdx] = w;
    if (t == 4) expTag[slotIdx] = "R5";
    else if (t <= 1) expTag[slotIdx] = "R6";
    else if (tag == "R6") expTag[slotIdx] = "R4";
    else expTag[slotIdx] = tag;
    slotIdx++;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // sweep every event combination at every cycle of the slot (R3, R7, R8)
    for (int k = 1; k < 8; k++) begin
      for (int p = 0; p < DIV; p++) begin
        string tg;
        bit [3:0] m;
        m = 4'(1 << p);
        if (k == 3) tg = "R7";
        else if (k >= 5) tg = "R8";
        else tg = "R3";
        runSlot(tg, k[0] ? m : 4'b0, k[1] ? m : 4'b0, k[2] ? m : 4'b0, (k * 37 + p * 101) % 1024);
        for (int q = 0; q < 3; q++) runSlot("R6", 4'b0, 4'b0, 4'b0, 0);
      end
    end
    // R9: repeated strobes merge, strobe in last cycle counts
    runSlot("R9", 4'b1001, 4'b0101, 4'b0000, 77);
    runSlot("R9", 4'b0000, 4'b1000, 4'b0000, 500);
    runSlot("R9", 4'b0000, 4'b0010, 4'b0000, 9);
    runSlot("R6", 4'b0, 4'b0, 4'b0, 0);
    runSlot("R6", 4'b0, 4'b0, 4'b0, 0);
    // R8: address word is not displaced by later higher-priority events
    runSlot("R8", 4'b0000, 4'b0001, 4'b0000, 1023);
    runSlot("R8", 4'b0001, 4'b0000, 4'b0001, 3);
    // back-to-back busy stream
    runSlot("R8", 4'b0100, 4'b0100, 4'b0100, 640);
    runSlot("R8", 4'b0000, 4'b0010, 4'b0010, 641);
    for (int q = 0; q < LAT + 6; q++) runSlot("R6", 4'b0, 4'b0, 4'b0, 0);
    sofEvt = 1'b0; solEvt = 1'b0; eolEvt = 1'b0;
    done = 1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      finishRun();
    end
  end

endmodule